// File: doc/BRIEF.md
# Windowed Memory Select Decoder

This block decides whether a memory board answers a bus access, and which of its RAM windows takes part. The board carries three 8 KB windows (A, B and C) on a 16-bit address bus. Each window has a 3-bit base setting that must equal the top three address bits, so a window can start on any 8 KB boundary from 0000H to E000H. Windows need not be contiguous and may overlap. When they overlap, the lowest-lettered window wins, so only one RAM drives the data bus.

Each window has its own write-enable setting. A write into a protected window still completes as a bus cycle: the board responds, but the write strobe to the RAM is held off and a protect-violation level is raised for the duration of the access. The whole board is gated by a bank-active input from an external bank-select latch. An optional phantom override deselects the board while the active-low phantom line is asserted.

The configuration inputs are captured into shadow registers only on clock edges where no memory strobe is active, so a change made mid-access takes effect once the bus goes idle. All decode outputs are combinational from the address, strobes, gating inputs and the shadow configuration. The offset within a window (A12..A0) passes straight through to the RAM.

Top module: `win_mem_decoder`

## Requirements
- R1: With the board enabled and a strobe active, window i (A=0, B=1, C=2; base in `cfg_base[3*i+2:3*i]`) matches when `addr[15:13]` equals its shadow base, so it covers base*2000H through base*2000H+1FFFH.
- R2: `win_offset` always equals `addr[12:0]`.
- R3: `win_sel` is one-hot or zero; bit i stands for window i, and when several windows match only the lowest-numbered one is selected.
- R4: A write (`mem_wr`=1, `mem_rd`=0) to a selected window whose shadow write enable (`cfg_wr_en[i]`) is 0 keeps `board_respond` high, holds `win_wr_strobe` low and raises `prot_violation`; reads of that window are unaffected, and a write to an enabled window raises `win_wr_strobe` with no violation.
- R5: While `bank_active` is 0, `win_sel`, `board_respond`, `data_oe`, `win_wr_strobe` and `prot_violation` are all 0.
- R6: When the shadow phantom-honour bit is 1 and `phantom_n` is 0, the board is deselected as in R5; when the bit is 0, `phantom_n` has no effect.
- R7: `data_oe` is 1 only when the board responds with `mem_rd`=1 and `mem_wr`=0; with both strobes high the board selects but neither drives data nor writes.
- R8: The shadow configuration loads from the cfg inputs on each clock edge with both strobes low and holds otherwise; synchronous reset clears it (all bases 0, all write enables 0, phantom honour 0).
- R9: With both strobes low, no window is selected and `board_respond` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the shadow configuration |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_base | input | 9 | Window bases, 3 bits per window, window A in the low bits |
| cfg_wr_en | input | 3 | Per-window write enable, bit 0 = window A |
| cfg_phantom_honour | input | 1 | 1 = obey the phantom line |
| addr | input | 16 | Bus address |
| mem_rd | input | 1 | Memory read strobe |
| mem_wr | input | 1 | Memory write strobe |
| bank_active | input | 1 | Board enabled by the bank-select latch |
| phantom_n | input | 1 | Active-low phantom line |
| win_sel | output | 3 | One-hot window chip selects |
| win_offset | output | 13 | Offset within the window |
| board_respond | output | 1 | Board answers this access |
| data_oe | output | 1 | Drive read data onto the bus |
| win_wr_strobe | output | 1 | Write strobe to the selected RAM |
| prot_violation | output | 1 | Write blocked by window protection |

## Verification
The bench builds the block with its default parameters: a 16-bit address, 3-bit bases and three windows. With three windows placed among only eight base slots, random configurations overlap often, so the priority rule of R3 is exercised heavily alongside directed full-overlap cases. Every base value and every write-enable pattern is reachable, and the bench also changes the configuration while a strobe is held, which brings the hold rule of R8 within reach.

// File: rtl/wmd_pkg.sv
// Shared types for the windowed memory decoder.
// Assumes strobes are single-bit active-high levels.
package wmd_pkg;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2,
        ACC_BOTH  = 2'd3
    } acc_e;

    // Classify the bus access from the two strobes.
    function automatic acc_e classify(input logic rd, input logic wr);
        acc_e k;
        unique case ({wr, rd})
            2'b01:   k = ACC_READ;
            2'b10:   k = ACC_WRITE;
            2'b11:   k = ACC_BOTH;
            default: k = ACC_IDLE;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/wmd_cfg_shadow.sv
// Shadow copy of the window configuration.
// Loads from the configuration inputs only on edges where the bus is idle,
// so a change made during an access cannot disturb it. Synchronous reset
// clears every field.
module wmd_cfg_shadow #(
    parameter int NUM_WIN = 3,
    parameter int BASE_W  = 3,
    localparam int CFG_W  = NUM_WIN * BASE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               busy,
    input  logic [CFG_W-1:0]   cfg_base,
    input  logic [NUM_WIN-1:0] cfg_wr_en,
    input  logic               cfg_honour,
    output logic [CFG_W-1:0]   base_q,
    output logic [NUM_WIN-1:0] wr_en_q,
    output logic               honour_q
);

    // Capture configuration while idle, hold it while a strobe is active.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q   <= '0;
            wr_en_q  <= '0;
            honour_q <= 1'b0;
        end else if (!busy) begin
            base_q   <= cfg_base;
            wr_en_q  <= cfg_wr_en;
            honour_q <= cfg_honour;
        end
    end

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(base_q) && $stable(wr_en_q) && $stable(honour_q))); // R8

endmodule

// File: rtl/wmd_match.sv
// Per-window base comparators.
// Each window compares its base with the top address bits; every hit is
// qualified by the board-level enable. Assumes enable already folds in the
// strobes, the bank flag and the phantom override.
module wmd_match #(
    parameter int NUM_WIN = 3,
    parameter int BASE_W  = 3,
    parameter int ADDR_W  = 16,
    localparam int CFG_W  = NUM_WIN * BASE_W
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic [CFG_W-1:0]   base_q,
    input  logic               enable,
    output logic [NUM_WIN-1:0] hit
);

    logic [BASE_W-1:0] top_bits;

    // Extract the window-number bits of the address.
    always_comb begin
        top_bits = addr[ADDR_W-1 -: BASE_W];
    end

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
        // Compare one window's base with the address.
        always_comb begin
            hit[i] = enable && (base_q[i*BASE_W +: BASE_W] == top_bits);
        end
    end

endmodule

// File: rtl/wmd_pick.sv
// Fixed-priority picker: of all matching windows only the lowest-numbered
// is selected, so at most one RAM drives the bus.
module wmd_pick #(
    parameter int NUM_WIN = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_WIN-1:0] hit,
    output logic [NUM_WIN-1:0] sel
);

    localparam logic [NUM_WIN-1:0] ONE = NUM_WIN'(1);

    // Walk from window 0 upward and keep the first hit.
    always_comb begin
        logic found;
        found = 1'b0;
        sel   = '0;
        for (int i = 0; i < NUM_WIN; i++) begin
            if (hit[i] && !found) begin
                sel[i] = 1'b1;
                found  = 1'b1;
            end
        end
    end

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel)); // R3
    AST_SEL_IN_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        ((sel & ~hit) == '0)); // R1
    AST_HIT_GETS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (hit != '0) |-> (sel != '0)); // R1
    AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ((hit & (sel - ONE)) == '0)); // R3

endmodule

// File: rtl/wmd_wr_gate.sv
// Response, read-drive and write-gating logic.
// Turns the selected window and the access kind into the board response,
// the data-out enable, the RAM write strobe and the protect-violation level.
// Assumes sel is one-hot or zero.
module wmd_wr_gate #(
    parameter int NUM_WIN = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_WIN-1:0] sel,
    input  logic [NUM_WIN-1:0] wr_en_q,
    input  logic               mem_rd,
    input  logic               mem_wr,
    output logic               respond,
    output logic               data_oe,
    output logic               wr_strobe,
    output logic               prot_viol
);

    import wmd_pkg::*;

    acc_e kind;
    logic allowed;

    // Classify the access and look up the selected window's write enable.
    always_comb begin
        kind    = classify(mem_rd, mem_wr);
        allowed = |(sel & wr_en_q);
        respond = |sel;
    end

    // Drive the bus-side controls for the access kind.
    always_comb begin
        data_oe   = 1'b0;
        wr_strobe = 1'b0;
        prot_viol = 1'b0;
        if (respond) begin
            unique case (kind)
                ACC_READ:  data_oe = 1'b1;
                ACC_WRITE: begin
                    wr_strobe = allowed;
                    prot_viol = !allowed;
                end
                default: ;
            endcase
        end
    end

    AST_PROT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        prot_viol |-> (!wr_strobe && respond)); // R4
    AST_STROBE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe |-> ((sel & wr_en_q) != '0)); // R4
    AST_OE_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> (mem_rd && !mem_wr && !wr_strobe)); // R7

endmodule

// File: rtl/win_mem_decoder.sv
// Windowed memory select decoder, top level.
// Decodes a bus access onto one of NUM_WIN RAM windows, each placed on a
// window-size boundary by its own base, with per-window write protection,
// a bank-active gate and an optional phantom override. Outputs are
// combinational; configuration is taken through an idle-only shadow.
module win_mem_decoder #(
    parameter int ADDR_W  = 16,
    parameter int BASE_W  = 3,
    parameter int NUM_WIN = 3,
    localparam int CFG_W  = NUM_WIN * BASE_W,
    localparam int OFFS_W = ADDR_W - BASE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CFG_W-1:0]   cfg_base,
    input  logic [NUM_WIN-1:0] cfg_wr_en,
    input  logic               cfg_phantom_honour,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               mem_rd,
    input  logic               mem_wr,
    input  logic               bank_active,
    input  logic               phantom_n,
    output logic [NUM_WIN-1:0] win_sel,
    output logic [OFFS_W-1:0]  win_offset,
    output logic               board_respond,
    output logic               data_oe,
    output logic               win_wr_strobe,
    output logic               prot_violation
);

    logic               busy;
    logic               enable;
    logic [CFG_W-1:0]   base_q;
    logic [NUM_WIN-1:0] wr_en_q;
    logic               honour_q;
    logic [NUM_WIN-1:0] hit;

    // Board-level gate: a strobe, the bank flag and the phantom override.
    always_comb begin
        busy       = mem_rd || mem_wr;
        enable     = busy && bank_active && !(honour_q && !phantom_n);
        win_offset = addr[OFFS_W-1:0];
    end

    wmd_cfg_shadow #(.NUM_WIN(NUM_WIN), .BASE_W(BASE_W)) u_shadow (
        .clk        (clk),
        .rst_n      (rst_n),
        .busy       (busy),
        .cfg_base   (cfg_base),
        .cfg_wr_en  (cfg_wr_en),
        .cfg_honour (cfg_phantom_honour),
        .base_q     (base_q),
        .wr_en_q    (wr_en_q),
        .honour_q   (honour_q)
    );

    wmd_match #(.NUM_WIN(NUM_WIN), .BASE_W(BASE_W), .ADDR_W(ADDR_W)) u_match (
        .addr   (addr),
        .base_q (base_q),
        .enable (enable),
        .hit    (hit)
    );

    wmd_pick #(.NUM_WIN(NUM_WIN)) u_pick (
        .clk   (clk),
        .rst_n (rst_n),
        .hit   (hit),
        .sel   (win_sel)
    );

    wmd_wr_gate #(.NUM_WIN(NUM_WIN)) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (win_sel),
        .wr_en_q   (wr_en_q),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .respond   (board_respond),
        .data_oe   (data_oe),
        .wr_strobe (win_wr_strobe),
        .prot_viol (prot_violation)
    );

    AST_BANK_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !bank_active |-> (win_sel == '0 && !board_respond && !win_wr_strobe
                          && !prot_violation && !data_oe)); // R5
    AST_PHANTOM_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (honour_q && !phantom_n) |-> (win_sel == '0 && !board_respond)); // R6
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (win_sel == '0 && !board_respond)); // R9
    AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        win_offset == addr[OFFS_W-1:0]); // R2

endmodule

// File: tb/win_mem_decoder_tb.sv
`timescale 1ns/1ps
module win_mem_decoder_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [8:0]  cfg_base;
    logic [2:0]  cfg_wr_en;
    logic        cfg_phantom_honour;
    logic [15:0] addr;
    logic        mem_rd, mem_wr, bank_active, phantom_n;
    logic [2:0]  win_sel;
    logic [12:0] win_offset;
    logic        board_respond, data_oe, win_wr_strobe, prot_violation;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // bench model of the shadow configuration (R8)
    logic [8:0] m_base;
    logic [2:0] m_wen;
    logic       m_hon;

    always #2.5 clk = ~clk;

    win_mem_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_wr_en(cfg_wr_en),
        .cfg_phantom_honour(cfg_phantom_honour), .addr(addr), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .bank_active(bank_active), .phantom_n(phantom_n),
        .win_sel(win_sel), .win_offset(win_offset), .board_respond(board_respond),
        .data_oe(data_oe), .win_wr_strobe(win_wr_strobe), .prot_violation(prot_violation)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_base <= '0; m_wen <= '0; m_hon <= 1'b0;
        end else if (!(mem_rd || mem_wr)) begin
            m_base <= cfg_base; m_wen <= cfg_wr_en; m_hon <= cfg_phantom_honour;
        end
    end

    task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Expected outputs from the requirements and the model shadow.
    task automatic check_outputs(input string tag);
        logic [2:0] e_sel;
        logic e_resp, e_oe, e_str, e_vio, en, allowed;
        en = (mem_rd || mem_wr) && bank_active && !(m_hon && !phantom_n);
        e_sel = 3'b000;
        for (int i = 2; i >= 0; i--)
            if (en && m_base[i*3 +: 3] == addr[15:13]) e_sel = 3'b001 << i;
        e_resp  = (e_sel != 0);
        allowed = ((e_sel & m_wen) != 0);
        e_oe    = e_resp && mem_rd && !mem_wr;
        e_str   = e_resp && mem_wr && !mem_rd && allowed;
        e_vio   = e_resp && mem_wr && !mem_rd && !allowed;
        check_eq({tag, " win_sel"}, 32'(win_sel), 32'(e_sel));
        check_eq({tag, " R2 offset"}, 32'(win_offset), 32'(addr[12:0]));
        check_eq({tag, " respond"}, 32'(board_respond), 32'(e_resp));
        check_eq({tag, " R7 data_oe"}, 32'(data_oe), 32'(e_oe));
        check_eq({tag, " wr_strobe"}, 32'(win_wr_strobe), 32'(e_str));
        check_eq({tag, " violation"}, 32'(prot_violation), 32'(e_vio));
    endtask

    task automatic set_cfg(input logic [8:0] b, input logic [2:0] w, input logic h);
        @(negedge clk);
        cfg_base = b; cfg_wr_en = w; cfg_phantom_honour = h;
        mem_rd = 1'b0; mem_wr = 1'b0;
        @(posedge clk);
    endtask

    task automatic access(input logic [15:0] a, input logic rd, input logic wr, input string tag);
        @(negedge clk);
        addr = a; mem_rd = rd; mem_wr = wr;
        #1;
        check_outputs(tag);
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240607));
        rst_n = 1'b0;
        cfg_base = 9'b111_110_101; cfg_wr_en = 3'b111; cfg_phantom_honour = 1'b1;
        addr = 16'h0100; mem_rd = 1'b0; mem_wr = 1'b1; bank_active = 1'b1; phantom_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R8 reset state: bases 0, writes disabled, phantom ignored
        check_eq("R8 reset sel", 32'(win_sel), 32'h1);
        check_eq("R8 reset violation", 32'(prot_violation), 32'h1);
        check_eq("R8 reset strobe", 32'(win_wr_strobe), 32'h0);
        phantom_n = 1'b1;

        // R1 example placement 2000H/4000H/6000H
        set_cfg({3'd3, 3'd2, 3'd1}, 3'b111, 1'b0);
        access(16'h2000, 1, 0, "R1 A low");
        check_eq("R1 A low sel", 32'(win_sel), 32'h1);
        access(16'h3FFF, 1, 0, "R1 A high");
        check_eq("R1 A high sel", 32'(win_sel), 32'h1);
        access(16'h4000, 1, 0, "R1 B");
        check_eq("R1 B sel", 32'(win_sel), 32'h2);
        access(16'h7FFF, 0, 1, "R1 C");
        check_eq("R1 C sel", 32'(win_sel), 32'h4);
        access(16'h8000, 1, 0, "R1 miss");
        check_eq("R1 miss respond", 32'(board_respond), 32'h0);
        access(16'h1FFF, 1, 0, "R1 below");

        // R9 idle: no strobe, no select
        access(16'h2000, 0, 0, "R9 idle");
        check_eq("R9 idle sel", 32'(win_sel), 32'h0);

        // R3 overlap
        set_cfg({3'd5, 3'd5, 3'd5}, 3'b111, 1'b0);
        access(16'hA123, 1, 0, "R3 all overlap");
        check_eq("R3 A wins", 32'(win_sel), 32'h1);
        set_cfg({3'd5, 3'd5, 3'd7}, 3'b111, 1'b0);
        access(16'hB000, 0, 1, "R3 B over C");
        check_eq("R3 B wins", 32'(win_sel), 32'h2);

        // R4 protection on window B
        set_cfg({3'd6, 3'd4, 3'd0}, 3'b101, 1'b0);
        access(16'h8010, 0, 1, "R4 blocked write");
        check_eq("R4 blocked strobe", 32'(win_wr_strobe), 32'h0);
        check_eq("R4 violation", 32'(prot_violation), 32'h1);
        check_eq("R4 still responds", 32'(board_respond), 32'h1);
        access(16'h8010, 1, 0, "R4 protected read");
        check_eq("R4 read oe", 32'(data_oe), 32'h1);
        access(16'hC010, 0, 1, "R4 allowed write");
        check_eq("R4 allowed strobe", 32'(win_wr_strobe), 32'h1);

        // R7 both strobes: select but neither drive nor write
        access(16'hC010, 1, 1, "R7 both");
        check_eq("R7 both oe", 32'(data_oe), 32'h0);

        // R5 bank inactive
        @(negedge clk); bank_active = 1'b0;
        access(16'hC010, 0, 1, "R5 inactive write");
        check_eq("R5 inactive respond", 32'(board_respond), 32'h0);
        access(16'h0000, 1, 0, "R5 inactive read");
        @(negedge clk); bank_active = 1'b1;

        // R6 phantom honoured / ignored
        set_cfg({3'd6, 3'd4, 3'd0}, 3'b111, 1'b1);
        @(negedge clk); phantom_n = 1'b0;
        access(16'h0004, 1, 0, "R6 honoured");
        check_eq("R6 honoured sel", 32'(win_sel), 32'h0);
        set_cfg({3'd6, 3'd4, 3'd0}, 3'b111, 1'b0);
        access(16'h0004, 1, 0, "R6 ignored");
        check_eq("R6 ignored sel", 32'(win_sel), 32'h1);
        @(negedge clk); phantom_n = 1'b1;

        // R8 config change during a held strobe does not take effect
        set_cfg({3'd0, 3'd0, 3'd1}, 3'b111, 1'b0);
        access(16'h2000, 1, 0, "R8 before");
        @(negedge clk); cfg_base = {3'd0, 3'd0, 3'd4};
        @(posedge clk);
        access(16'h2000, 1, 0, "R8 held");
        check_eq("R8 held sel", 32'(win_sel), 32'h1);
        access(16'h2000, 0, 0, "R8 idle load");
        access(16'h2000, 1, 0, "R8 after");
        check_eq("R8 after sel", 32'(win_sel), 32'h0);

        // constrained random mix (R1 R3 R4 R5 R6 R7 R8 R9)
        for (int it = 0; it < 600; it++) begin
            int unsigned k;
            @(negedge clk);
            if ($urandom_range(0, 3) != 0) begin
                cfg_base = 9'($urandom);
                cfg_wr_en = 3'($urandom);
                cfg_phantom_honour = 1'($urandom);
            end
            bank_active = ($urandom_range(0, 7) != 0);
            phantom_n = 1'($urandom);
            addr = 16'($urandom);
            k = $urandom_range(0, 9);
            mem_rd = (k < 4) || (k == 9);
            mem_wr = (k >= 4 && k < 8) || (k == 9);
            #1;
            check_outputs("R1/R3/R4/R5/R6/R7/R9 random");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule